// File: doc/BRIEF.md
# PCI Host Bridge Control Register File

This block is the CPU-facing control slave of a PCI host bridge. A 32-bit word bus reaches five things through it. The first is a 64-word local configuration-space window that describes the bridge's own PCI function. Next come three registers: a configuration-target address, a memory-window base and an I/O-window base. The last is a data port that reaches configuration space on the far side of the bridge.

An access to the data port is not served locally. The block stalls the CPU bus and issues exactly one configuration cycle on a simple request/acknowledge interface, using the address held in the configuration-target register. It releases the CPU bus in the cycle the acknowledge arrives. A read returns the data that comes back with the acknowledge.

The I/O-window base also drives a translation offset output. This offset selects a 256 KB window for an external address translator.

Top module: `pcib_regfile`

## Requirements
- R1: An access whose size code is not 2 (word) completes in the same cycle with err_o and ready_o high. It changes no register, window word or output, and it issues no downstream request. Size code 0 is a byte, 1 is a half-word and 3 is reserved.
- R2: Word-aligned offsets 0x000 to 0x0FC read and write the local window, one 32-bit word per offset, with single-cycle ready.
- R3: After reset, the word at offset 0x004 reads 0x02900080. That is the command half (wait-cycle bit 7) plus the status half (capabilities-list bit 4, fast back-to-back bit 7, medium DEVSEL code 01 in bits 10:9). Every other window word, all three registers and io_xlat_o are zero.
- R4: Offset 0x1C0 holds the configuration-target address and reads back all 32 written bits unchanged.
- R5: Offset 0x1C4 keeps only bits 31:24 and bit 0 of a write (mask 0xFF000001). Its other bits read zero.
- R6: Offset 0x1C8 keeps only bits 31:18 and bit 0 of a write (mask 0xFFFC0001). Its other bits read zero.
- R7: From the cycle after a word write to 0x1C8, io_xlat_o equals the written value ANDed with 0xFFFC0000.
- R8: A word write to offset 0x220 raises cfg_req_o with cfg_we_o=1, cfg_addr_o equal to the 0x1C0 register and cfg_wdata_o equal to the written word. ready_o stays low until the cycle in which cfg_ack_i is high.
- R9: A word read of offset 0x220 raises cfg_req_o with cfg_we_o=0 at the 0x1C0 address. In the acknowledge cycle, ready_o is high and rdata_o equals cfg_rdata_i.
- R10: A read of any other offset returns zero with ready_o high, and a write to one changes nothing.
- R11: Each data-port access produces exactly one request. cfg_req_o and its address, data and direction stay stable until acknowledged, and cfg_req_o falls in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU access request, held until ready_o |
| we_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 2 | Access size code, 2 means 32-bit word |
| addr_i | input | ADDR_W | Byte offset within the block |
| wdata_i | input | DW | Write data |
| ready_o | output | 1 | Access completes this cycle |
| err_o | output | 1 | Access rejected for its size |
| rdata_o | output | DW | Read data, valid with ready_o |
| cfg_req_o | output | 1 | Downstream configuration request |
| cfg_we_o | output | 1 | Downstream direction, 1 for write |
| cfg_addr_o | output | DW | Downstream configuration address |
| cfg_wdata_o | output | DW | Downstream write data |
| cfg_ack_i | input | 1 | Downstream acknowledge, one cycle |
| cfg_rdata_i | input | DW | Downstream read data, valid with cfg_ack_i |
| io_xlat_o | output | DW | I/O window translation offset |

## Verification
The hardest situation to reach is a data-port access held in its stall while the downstream side withholds its acknowledge. In that state the CPU request stays high across several clock edges and must be neither re-decoded nor re-issued. The bench provokes it with a responder model whose acknowledge delay is set per access. It checks the stall length in cycles, that only one request was seen, and that the direction, address and data carried the configuration register and the written word. A rejected data-port access with a bad size is also driven, to show that no request leaks out.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} acc_size_e;
  typedef enum logic {PORT_IDLE = 1'b0, PORT_WAIT = 1'b1} port_state_e;

  localparam int unsigned OFF_CFG_ADDR  = 32'h1C0;
  localparam int unsigned OFF_MEM_BASE  = 32'h1C4;
  localparam int unsigned OFF_IO_BASE   = 32'h1C8;
  localparam int unsigned OFF_DATA_PORT = 32'h220;

  localparam logic [31:0] MEM_BASE_MASK  = 32'hFF00_0001;
  localparam logic [31:0] IO_BASE_MASK   = 32'hFFFC_0001;
  localparam logic [31:0] IO_XLAT_MASK   = 32'hFFFC_0000;
  localparam logic [31:0] CMD_STAT_RESET = 32'h0290_0080;
  localparam int unsigned CMD_STAT_IDX   = 1;
endpackage

// File: rtl/pcib_cfg_window.sv
module pcib_cfg_window #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 64,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  import pcib_pkg::*;

  logic [DW-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [DW-1:0] RST_VAL = (i == CMD_STAT_IDX) ? DW'(CMD_STAT_RESET) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[i] <= RST_VAL;
      else if (we_i && idx_i == IDX_W'(i))  mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/pcib_base_regs.sv
module pcib_base_regs #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_cfg_addr_i,
  input  logic          wr_mem_base_i,
  input  logic          wr_io_base_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_addr_o,
  output logic [DW-1:0] mem_base_o,
  output logic [DW-1:0] io_base_o,
  output logic [DW-1:0] io_xlat_o
);
  import pcib_pkg::*;

  logic [DW-1:0] cfg_addr_q, mem_base_q, io_base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_addr_q <= '0;
      mem_base_q <= '0;
      io_base_q  <= '0;
    end else begin
      if (wr_cfg_addr_i) cfg_addr_q <= wdata_i;
      if (wr_mem_base_i) mem_base_q <= wdata_i & DW'(MEM_BASE_MASK);
      if (wr_io_base_i)  io_base_q  <= wdata_i & DW'(IO_BASE_MASK);
    end
  end

  assign cfg_addr_o = cfg_addr_q;
  assign mem_base_o = mem_base_q;
  assign io_base_o  = io_base_q;
  // enable bit dropped: translator only needs the window offset
  assign io_xlat_o  = io_base_q & DW'(IO_XLAT_MASK);
endmodule

// File: rtl/pcib_cfg_port.sv
module pcib_cfg_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output logic [DW-1:0] cfg_addr_o,
  output logic [DW-1:0] cfg_wdata_o,
  input  logic          cfg_ack_i
);
  import pcib_pkg::*;

  port_state_e   state_q;
  logic          we_q;
  logic [DW-1:0] addr_q, wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PORT_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        PORT_IDLE: if (start_i) begin
          state_q <= PORT_WAIT;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        PORT_WAIT: if (cfg_ack_i) state_q <= PORT_IDLE;
        default:   state_q <= PORT_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q == PORT_WAIT);
  assign done_o      = busy_o && cfg_ack_i;
  assign cfg_req_o   = busy_o;
  assign cfg_we_o    = we_q;
  assign cfg_addr_o  = addr_q;
  assign cfg_wdata_o = wdata_q;
endmodule

// File: rtl/pcib_regfile.sv
module pcib_regfile #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DW     = 32,
  parameter int unsigned WORDS  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              ready_o,
  output logic              err_o,
  output logic [DW-1:0]     rdata_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [DW-1:0]     cfg_addr_o,
  output logic [DW-1:0]     cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic [DW-1:0]     cfg_rdata_i,
  output logic [DW-1:0]     io_xlat_o
);
  import pcib_pkg::*;

  localparam int unsigned IDX_W = $clog2(WORDS);

  logic          port_busy, port_done;
  logic          acc, bad, good;
  logic          hit_win, hit_cfg, hit_mem, hit_io, hit_dp;
  logic [DW-1:0] win_rdata, cfg_addr_q, mem_base_q, io_base_q;

  // a stalled data-port access is not decoded again
  assign acc  = req_i && !port_busy;
  assign bad  = acc && (size_i != SZ_WORD);
  assign good = acc && (size_i == SZ_WORD);

  assign hit_win = (addr_i[1:0] == 2'b00) && (32'(addr_i[ADDR_W-1:2]) < WORDS);
  assign hit_cfg = (32'(addr_i) == OFF_CFG_ADDR);
  assign hit_mem = (32'(addr_i) == OFF_MEM_BASE);
  assign hit_io  = (32'(addr_i) == OFF_IO_BASE);
  assign hit_dp  = (32'(addr_i) == OFF_DATA_PORT);

  pcib_cfg_window #(.DW(DW), .WORDS(WORDS)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (good && we_i && hit_win),
    .idx_i   (addr_i[2 +: IDX_W]),
    .wdata_i (wdata_i),
    .rdata_o (win_rdata)
  );

  pcib_base_regs #(.DW(DW)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_cfg_addr_i (good && we_i && hit_cfg),
    .wr_mem_base_i (good && we_i && hit_mem),
    .wr_io_base_i  (good && we_i && hit_io),
    .wdata_i       (wdata_i),
    .cfg_addr_o    (cfg_addr_q),
    .mem_base_o    (mem_base_q),
    .io_base_o     (io_base_q),
    .io_xlat_o     (io_xlat_o)
  );

  pcib_cfg_port #(.DW(DW)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (good && hit_dp),
    .we_i        (we_i),
    .addr_i      (cfg_addr_q),
    .wdata_i     (wdata_i),
    .busy_o      (port_busy),
    .done_o      (port_done),
    .cfg_req_o   (cfg_req_o),
    .cfg_we_o    (cfg_we_o),
    .cfg_addr_o  (cfg_addr_o),
    .cfg_wdata_o (cfg_wdata_o),
    .cfg_ack_i   (cfg_ack_i)
  );

  assign ready_o = bad || (good && !hit_dp) || port_done;
  assign err_o   = bad;

  always_comb begin
    rdata_o = '0;
    if (port_done)    rdata_o = cfg_rdata_i;
    else if (good) begin
      if (hit_win)      rdata_o = win_rdata;
      else if (hit_cfg) rdata_o = cfg_addr_q;
      else if (hit_mem) rdata_o = mem_base_q;
      else if (hit_io)  rdata_o = io_base_q;
    end
  end
endmodule

// File: rtl/pcib_regfile_chk.sv
module pcib_regfile_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DW     = 32,
  parameter int unsigned WORDS  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              ready_o,
  input logic              err_o,
  input logic [DW-1:0]     rdata_o,
  input logic              cfg_req_o,
  input logic              cfg_we_o,
  input logic [DW-1:0]     cfg_addr_o,
  input logic [DW-1:0]     cfg_wdata_o,
  input logic              cfg_ack_i,
  input logic [DW-1:0]     cfg_rdata_i,
  input logic [DW-1:0]     io_xlat_o
);
  import pcib_pkg::*;

  logic unmapped;
  assign unmapped = (32'(addr_i) >= WORDS * 4) && (32'(addr_i) != OFF_CFG_ADDR) &&
                    (32'(addr_i) != OFF_MEM_BASE) && (32'(addr_i) != OFF_IO_BASE) &&
                    (32'(addr_i) != OFF_DATA_PORT);

  // R1
  bad_size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (size_i != SZ_WORD) |-> err_o && ready_o);
  // R1
  bad_size_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (size_i != SZ_WORD) && !cfg_req_o |=> !cfg_req_o && $stable(io_xlat_o));
  // R7
  xlat_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && ready_o && !err_o && (32'(addr_i) == OFF_IO_BASE)
    |=> io_xlat_o == ($past(wdata_i) & DW'(IO_XLAT_MASK)));
  // R8
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |-> !ready_o);
  // R9
  read_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i && !cfg_we_o |-> ready_o && (rdata_o == cfg_rdata_i));
  // R10
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && ready_o && !err_o && !cfg_req_o && unmapped |-> rdata_o == '0);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_addr_o) && $stable(cfg_we_o)
    && $stable(cfg_wdata_o));
  // R11
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i |=> !cfg_req_o);
  // R1
  err_implies_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ready_o);
endmodule

bind pcib_regfile pcib_regfile_chk #(.ADDR_W(ADDR_W), .DW(DW), .WORDS(WORDS)) u_chk (.*);

// File: tb/pcib_regfile_bench.sv
module pcib_regfile_bench;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DW     = 32;

  typedef struct packed {
    logic [31:0] data;
    logic        err;
    logic        chk_data;
    logic [3:0]  rq;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [1:0]        size = 2'd2;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic              ready, err;
  logic [DW-1:0]     rdata;
  logic              cfg_req, cfg_we;
  logic [DW-1:0]     cfg_addr, cfg_wdata;
  logic              cfg_ack = 1'b0;
  logic [DW-1:0]     cfg_rdata = '0;
  logic [DW-1:0]     io_xlat;

  int   checks = 0, errors = 0;
  exp_t sb_q[$];
  int   resp_delay = 0;
  int   dn_count = 0;
  logic seen_we;
  logic [DW-1:0] seen_addr, seen_data;
  int   last_stall = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pcib_regfile #(.ADDR_W(ADDR_W), .DW(DW), .WORDS(64)) u_pcib_regfile (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .ready_o(ready), .err_o(err), .rdata_o(rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr),
    .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata),
    .io_xlat_o(io_xlat)
  );

  function automatic logic [31:0] model_rd(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic check(bit ok, int rq, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d: actual %08h expected %08h", rq, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: pushes the expectation, then performs the access
  task automatic access(logic w, logic [ADDR_W-1:0] a, logic [1:0] sz, logic [31:0] d,
                        logic [31:0] exp_d, logic exp_e, logic chk_d, int rq);
    exp_t e;
    e.data = exp_d; e.err = exp_e; e.chk_data = chk_d; e.rq = 4'(rq);
    sb_q.push_back(e);
    @(posedge clk); #1;
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    last_stall = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      last_stall++;
    end
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  // monitor: compares each completed access with the queue head
  always @(negedge clk) begin
    if (rst_n && req && ready) begin
      if (sb_q.size() == 0) check(1'b0, 0, 32'h0, 32'h1);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(err == e.err, int'(e.rq), 32'(err), 32'(e.err));
        if (e.chk_data) check(rdata == e.data, int'(e.rq), rdata, e.data);
      end
    end
  end

  // downstream responder with programmable acknowledge delay
  initial begin
    forever begin
      @(posedge clk); #2;
      if (cfg_req) begin
        dn_count++;
        seen_we = cfg_we; seen_addr = cfg_addr; seen_data = cfg_wdata;
        repeat (resp_delay) begin @(posedge clk); #2; end
        cfg_rdata = model_rd(seen_addr);
        cfg_ack = 1'b1;
        @(posedge clk); #2;
        cfg_ack = 1'b0;
        cfg_rdata = '0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, 0, 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    int n0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(io_xlat == 32'h0, 3, io_xlat, 32'h0);                      // R3
    access(0, 10'h004, 2, 0, 32'h0290_0080, 0, 1, 3);                 // R3 command/status
    access(0, 10'h000, 2, 0, 32'h0, 0, 1, 3);                         // R3
    access(0, 10'h0FC, 2, 0, 32'h0, 0, 1, 3);                         // R3
    access(0, 10'h1C0, 2, 0, 32'h0, 0, 1, 3);                         // R3
    access(0, 10'h1C4, 2, 0, 32'h0, 0, 1, 3);                         // R3
    access(0, 10'h1C8, 2, 0, 32'h0, 0, 1, 3);                         // R3

    access(1, 10'h010, 2, 32'hDEAD_BEEF, 0, 0, 0, 2);                 // R2
    access(1, 10'h0FC, 2, 32'h1234_5678, 0, 0, 0, 2);                 // R2
    access(1, 10'h004, 2, 32'h1111_2222, 0, 0, 0, 2);                 // R2
    access(0, 10'h010, 2, 0, 32'hDEAD_BEEF, 0, 1, 2);                 // R2
    access(0, 10'h0FC, 2, 0, 32'h1234_5678, 0, 1, 2);                 // R2
    access(0, 10'h004, 2, 0, 32'h1111_2222, 0, 1, 2);                 // R2

    access(1, 10'h1C0, 2, 32'hA5A5_5A5A, 0, 0, 0, 4);                 // R4
    access(0, 10'h1C0, 2, 0, 32'hA5A5_5A5A, 0, 1, 4);                 // R4

    access(1, 10'h1C4, 2, 32'hFFFF_FFFF, 0, 0, 0, 5);                 // R5
    access(0, 10'h1C4, 2, 0, 32'hFF00_0001, 0, 1, 5);                 // R5
    access(1, 10'h1C4, 2, 32'h00FF_FFFE, 0, 0, 0, 5);                 // R5
    access(0, 10'h1C4, 2, 0, 32'h0, 0, 1, 5);                         // R5

    access(1, 10'h1C8, 2, 32'hFFFF_FFFF, 0, 0, 0, 6);                 // R6
    access(0, 10'h1C8, 2, 0, 32'hFFFC_0001, 0, 1, 6);                 // R6
    check(io_xlat == 32'hFFFC_0000, 7, io_xlat, 32'hFFFC_0000);      // R7
    access(1, 10'h1C8, 2, 32'h1234_5679, 0, 0, 0, 6);                 // R6
    access(0, 10'h1C8, 2, 0, 32'h1234_5679 & 32'hFFFC_0001, 0, 1, 6); // R6
    check(io_xlat == (32'h1234_5679 & 32'hFFFC_0000), 7, io_xlat,
          32'h1234_5679 & 32'hFFFC_0000);                            // R7

    // R1: rejected sizes change nothing and issue nothing
    access(1, 10'h1C4, 1, 32'hFFFF_FFFF, 0, 1, 0, 1);
    access(1, 10'h1C8, 0, 32'h0000_0000, 0, 1, 0, 1);
    access(0, 10'h1C4, 2, 0, 32'h0, 0, 1, 1);
    check(io_xlat == (32'h1234_5679 & 32'hFFFC_0000), 1, io_xlat,
          32'h1234_5679 & 32'hFFFC_0000);
    n0 = dn_count;
    access(0, 10'h220, 3, 0, 0, 1, 0, 1);
    access(1, 10'h220, 0, 32'h0BAD_0BAD, 0, 1, 0, 1);
    check(dn_count == n0, 1, 32'(dn_count), 32'(n0));

    // R10: unmapped offsets
    access(1, 10'h100, 2, 32'h7777_7777, 0, 0, 0, 10);
    access(0, 10'h100, 2, 0, 32'h0, 0, 1, 10);
    access(1, 10'h1CC, 2, 32'h6666_6666, 0, 0, 0, 10);
    access(0, 10'h1CC, 2, 0, 32'h0, 0, 1, 10);
    access(0, 10'h3FC, 2, 0, 32'h0, 0, 1, 10);
    access(0, 10'h010, 2, 0, 32'hDEAD_BEEF, 0, 1, 10);

    // R8: data-port write with delayed acknowledge
    access(1, 10'h1C0, 2, 32'h8000_0810, 0, 0, 0, 8);
    resp_delay = 3;
    n0 = dn_count;
    access(1, 10'h220, 2, 32'hCAFE_F00D, 0, 0, 0, 8);
    check(seen_we == 1'b1, 8, 32'(seen_we), 32'h1);
    check(seen_addr == 32'h8000_0810, 8, seen_addr, 32'h8000_0810);
    check(seen_data == 32'hCAFE_F00D, 8, seen_data, 32'hCAFE_F00D);
    check(last_stall == 4, 8, 32'(last_stall), 32'd4);
    check(dn_count == n0 + 1, 11, 32'(dn_count), 32'(n0 + 1));      // R11
    check(cfg_req == 1'b0, 11, 32'(cfg_req), 32'h0);                 // R11

    // R9: data-port read, longer delay, new target address
    access(1, 10'h1C0, 2, 32'h8000_1A04, 0, 0, 0, 9);
    resp_delay = 5;
    n0 = dn_count;
    access(0, 10'h220, 2, 0, model_rd(32'h8000_1A04), 0, 1, 9);
    check(seen_we == 1'b0, 9, 32'(seen_we), 32'h0);
    check(seen_addr == 32'h8000_1A04, 9, seen_addr, 32'h8000_1A04);
    check(last_stall == 6, 9, 32'(last_stall), 32'd6);
    check(dn_count == n0 + 1, 11, 32'(dn_count), 32'(n0 + 1));      // R11

    // R9: zero-delay acknowledge
    resp_delay = 0;
    access(0, 10'h220, 2, 0, model_rd(32'h8000_1A04), 0, 1, 9);
    check(last_stall == 1, 9, 32'(last_stall), 32'd1);

    repeat (3) @(posedge clk);
    check(sb_q.size() == 0, 2, 32'(sb_q.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule